// File: doc/BRIEF.md
# UART Control and Interrupt Register

This block is the control register of a serial port. It holds the enables for the receiver and the transmitter and for three interrupt sources. It also holds the high bit of the character-size code and the ninth transmit data bit. On read-back it shows the ninth bit of the last received character. A host writes and reads the register over a simple one-cycle port. The serial shifters around it supply their status flags. The register gates each flag with its own enable and with a global interrupt enable to form three interrupt requests.

The block also decides when the transmitter owns the TxD pin. Setting the transmitter enable gives the transmitter the pin at once. Clearing the enable does not release the pin while the transmit buffer or the shift register still holds data. Ownership ends only when both are empty. Setting the enable again during that drain cancels the shutdown without a gap in ownership. Software writes the ninth transmit bit before the low data byte. It reads the received ninth bit before the low data byte.

Top module: `uart_ctl_reg`

## Requirements
- R1: After reset every stored bit is 0. The read value is then 0 except at bit 1, which shows `rx_bit9_i`.
- R2: A write with `wr_en_i` high stores `wr_data_i` bits 7..2 and 0 at the clock edge. The stored bits stay unchanged while `wr_en_i` is low. The combinational read returns them in these positions: 7 receive-done interrupt enable, 6 transmit-done interrupt enable, 5 buffer-empty interrupt enable, 4 receiver enable, 3 transmitter enable, 2 character-size high bit, 0 transmit ninth bit.
- R3: Bit 1 is read-only. Writing it has no effect, and a read at bit 1 always shows the current value of `rx_bit9_i`.
- R4: `irq_rx_o`, `irq_tx_o` and `irq_empty_o` are each high exactly when the matching enable (bit 7, 6 or 5) is 1, `glb_irq_en_i` is 1, and the matching flag (`rx_done_i`, `tx_done_i`, `buf_empty_i`) is 1.
- R5: `rx_en_o`, `char_size_hi_o` and `tx_bit9_o` follow stored bits 4, 2 and 0.
- R6: `tx_own_o` rises at the same clock edge that stores a 1 into the transmitter enable, and stays high while that bit is 1.
- R7: After the transmitter enable is cleared, `tx_own_o` stays high while `tx_shift_busy_i` or `tx_buf_full_i` is 1. It falls at the first clock edge at which the enable is clear and both of those inputs are 0.
- R8: Writing the transmitter enable back to 1 during a pending shutdown keeps `tx_own_o` high with no low cycle.
- R9: When `glb_irq_en_i` is 0, all three interrupt requests are 0 whatever the enables and flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register read value |
| rx_bit9_i | input | 1 | Ninth bit of the received character |
| rx_done_i | input | 1 | Receive-complete flag |
| tx_done_i | input | 1 | Transmit-complete flag |
| buf_empty_i | input | 1 | Transmit data register empty flag |
| glb_irq_en_i | input | 1 | Global interrupt enable |
| tx_shift_busy_i | input | 1 | Transmit shift register holds data |
| tx_buf_full_i | input | 1 | Transmit buffer holds data |
| irq_rx_o | output | 1 | Receive-complete interrupt request |
| irq_tx_o | output | 1 | Transmit-complete interrupt request |
| irq_empty_o | output | 1 | Buffer-empty interrupt request |
| rx_en_o | output | 1 | Receiver enable |
| char_size_hi_o | output | 1 | Character-size high bit |
| tx_bit9_o | output | 1 | Ninth transmit data bit |
| tx_own_o | output | 1 | Transmitter owns the TxD pin |

## Verification
The properties assume that the two transmit status inputs are synchronous to the clock. They also assume that a drain can end, meaning the shifter eventually clears both the busy and the full indication. The bench drives every input at the falling edge, so each input is stable across the rising edge. It always releases the busy and full inputs before it expects ownership to fall.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned IRQ_N   = 3;
  localparam int unsigned B_RXIE  = 7;
  localparam int unsigned B_TXIE  = 6;
  localparam int unsigned B_EMPIE = 5;
  localparam int unsigned B_RXEN  = 4;
  localparam int unsigned B_TXEN  = 3;
  localparam int unsigned B_CSZ   = 2;
  localparam int unsigned B_RXB9  = 1;
  localparam int unsigned B_TXB9  = 0;
  localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << B_RXB9);

  // Read view: stored bits with the live receive ninth bit spliced in.
  function automatic logic [REG_W-1:0] read_view(input logic [REG_W-1:0] stored,
                                                 input logic rx_b9);
    logic [REG_W-1:0] v;
    v = stored & WR_MASK;
    v[B_RXB9] = rx_b9;
    return v;
  endfunction

  // Next stored value after an optional write.
  function automatic logic [REG_W-1:0] next_store(input logic [REG_W-1:0] cur,
                                                  input logic we,
                                                  input logic [REG_W-1:0] wd);
    return we ? (wd & WR_MASK) : cur;
  endfunction
endpackage

// File: rtl/ucr_store.sv
module ucr_store
  import uart_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rx_bit9_i,
  output logic [REG_W-1:0] ctl_q_o,
  output logic [REG_W-1:0] ctl_d_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] ctl_q;

  assign ctl_d_o = next_store(ctl_q, wr_en_i, wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d_o;
  end

  assign ctl_q_o   = ctl_q;
  assign rd_data_o = read_view(ctl_q, rx_bit9_i);

  a_r2_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctl_q == ($past(wr_data_i) & WR_MASK)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctl_q));
endmodule

// File: rtl/ucr_irq.sv
module ucr_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] flag_i,
  input  logic         gie_i,
  output logic [N-1:0] req_o
);
  function automatic logic gate3(input logic e, input logic f, input logic g);
    return e & f & g;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_req
    assign req_o[i] = gate3(en_i[i], flag_i[i], gie_i);
  end

  a_r9_gie_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (req_o == '0));
  a_r4_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & ~(flag_i & en_i)) == '0);
endmodule

// File: rtl/ucr_txgate.sv
module ucr_txgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_d_i,
  input  logic en_q_i,
  input  logic shift_busy_i,
  input  logic buf_full_i,
  output logic own_o
);
  logic pending;
  logic own_q;
  logic stop_pend;

  assign pending   = shift_busy_i | buf_full_i;
  assign stop_pend = own_q & ~en_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= 1'b0;
    else         own_q <= en_d_i | (own_q & pending);
  end

  assign own_o = own_q;

  a_r6_own_when_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q_i |-> own_q);
  a_r7_hold_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_pend && pending) |=> own_q);
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_d_i && !pending) |=> !own_q);
  a_r8_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q && en_d_i) |=> own_q);
endmodule

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
  import uart_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       rx_bit9_i,
  input  logic       rx_done_i,
  input  logic       tx_done_i,
  input  logic       buf_empty_i,
  input  logic       glb_irq_en_i,
  input  logic       tx_shift_busy_i,
  input  logic       tx_buf_full_i,
  output logic       irq_rx_o,
  output logic       irq_tx_o,
  output logic       irq_empty_o,
  output logic       rx_en_o,
  output logic       char_size_hi_o,
  output logic       tx_bit9_o,
  output logic       tx_own_o
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] ctl_d;
  logic [IRQ_N-1:0] irq_en;
  logic [IRQ_N-1:0] irq_flag;
  logic [IRQ_N-1:0] irq_req;

  ucr_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rx_bit9_i (rx_bit9_i),
    .ctl_q_o   (ctl_q),
    .ctl_d_o   (ctl_d),
    .rd_data_o (rd_data_o)
  );

  assign irq_en   = {ctl_q[B_RXIE], ctl_q[B_TXIE], ctl_q[B_EMPIE]};
  assign irq_flag = {rx_done_i, tx_done_i, buf_empty_i};

  ucr_irq #(.N(IRQ_N)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (irq_en),
    .flag_i (irq_flag),
    .gie_i  (glb_irq_en_i),
    .req_o  (irq_req)
  );

  assign irq_rx_o    = irq_req[2];
  assign irq_tx_o    = irq_req[1];
  assign irq_empty_o = irq_req[0];

  ucr_txgate u_txgate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_d_i       (ctl_d[B_TXEN]),
    .en_q_i       (ctl_q[B_TXEN]),
    .shift_busy_i (tx_shift_busy_i),
    .buf_full_i   (tx_buf_full_i),
    .own_o        (tx_own_o)
  );

  assign rx_en_o        = ctl_q[B_RXEN];
  assign char_size_hi_o = ctl_q[B_CSZ];
  assign tx_bit9_o      = ctl_q[B_TXB9];
endmodule

// File: tb/uart_ctl_reg_tb.sv
module uart_ctl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rx_b9 = 1'b0, rx_done = 1'b0, tx_done = 1'b0, bempty = 1'b0;
  logic       gie = 1'b0, sh_busy = 1'b0, bfull = 1'b0;
  logic       irq_rx, irq_tx, irq_emp, rx_en, csz, txb9, own;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_ctl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rx_bit9_i(rx_b9), .rx_done_i(rx_done),
    .tx_done_i(tx_done), .buf_empty_i(bempty), .glb_irq_en_i(gie),
    .tx_shift_busy_i(sh_busy), .tx_buf_full_i(bfull),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_empty_o(irq_emp),
    .rx_en_o(rx_en), .char_size_hi_o(csz), .tx_bit9_o(txb9), .tx_own_o(own)
  );

  // Vector: {ie[2:0] (rx,tx,empty), flags[2:0] (rx,tx,empty), gie, expected irq[2:0]}
  localparam logic [9:0] VEC [12] = '{
    {3'b111, 3'b111, 1'b1, 3'b111},
    {3'b111, 3'b111, 1'b0, 3'b000},
    {3'b100, 3'b111, 1'b1, 3'b100},
    {3'b010, 3'b111, 1'b1, 3'b010},
    {3'b001, 3'b111, 1'b1, 3'b001},
    {3'b111, 3'b100, 1'b1, 3'b100},
    {3'b111, 3'b010, 1'b1, 3'b010},
    {3'b111, 3'b001, 1'b1, 3'b001},
    {3'b000, 3'b111, 1'b1, 3'b000},
    {3'b101, 3'b011, 1'b1, 3'b001},
    {3'b110, 3'b110, 1'b0, 3'b000},
    {3'b011, 3'b110, 1'b1, 3'b010}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rx_b9 = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state, bit 1 shows live rx ninth bit
    check("R1 reset read", rd_data, 8'h02);
    check("R1 reset outputs", {irq_rx, irq_tx, irq_emp, rx_en, csz, txb9, own, 1'b0}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_data, 8'h02);

    // R4/R9 vector walk
    for (int i = 0; i < 12; i++) begin
      wr({VEC[i][9:7], 5'b00000});
      {rx_done, tx_done, bempty} = VEC[i][6:4];
      gie = VEC[i][3];
      #1;
      check($sformatf("R4 R9 vec%0d", i), {5'b0, irq_rx, irq_tx, irq_emp}, {5'b0, VEC[i][2:0]});
    end
    gie = 1'b0; {rx_done, tx_done, bempty} = 3'b000;

    // R2 write and read-back, R3 bit1 ignored and live
    rx_b9 = 1'b0;
    wr(8'hFF);
    check("R2 R3 write FF", rd_data, 8'hFD);
    rx_b9 = 1'b1; #1;
    check("R3 live rx bit9", rd_data, 8'hFF);
    // R5 mirrors
    check("R5 mirrors", {5'b0, rx_en, csz, txb9}, 8'h07);
    wr(8'h56);
    check("R2 write 56", rd_data, 8'h56);
    check("R5 mirrors 56", {5'b0, rx_en, csz, txb9}, 8'h06);
    // R2 hold without strobe
    wr_data = 8'hAA;
    @(negedge clk);
    check("R2 hold", rd_data, 8'h56);
    rx_b9 = 1'b0;
    wr(8'h02);
    check("R3 write bit1 ignored", rd_data, 8'h00);

    // R6 ownership rises with enable
    wr(8'h00);
    check("R6 idle no own", {7'b0, own}, 8'h00);
    wr(8'h08);
    check("R6 own with enable", {7'b0, own}, 8'h01);

    // R7 deferred shutdown via shift busy
    sh_busy = 1'b1;
    wr(8'h00);
    check("R7 own held busy", {7'b0, own}, 8'h01);
    @(negedge clk);
    check("R7 still held", {7'b0, own}, 8'h01);
    sh_busy = 1'b0; bfull = 1'b1;
    @(negedge clk);
    check("R7 held buf full", {7'b0, own}, 8'h01);
    bfull = 1'b0;
    @(negedge clk);
    check("R7 release", {7'b0, own}, 8'h00);

    // R7 immediate when empty
    wr(8'h08);
    wr(8'h00);
    check("R7 empty immediate", {7'b0, own}, 8'h00);

    // R8 cancel pending shutdown
    wr(8'h08);
    bfull = 1'b1;
    wr(8'h00);
    check("R8 pending", {7'b0, own}, 8'h01);
    wr(8'h08);
    check("R8 re-enabled", {7'b0, own}, 8'h01);
    bfull = 1'b0;
    @(negedge clk);
    check("R8 stays owned", {7'b0, own}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule